// File: doc/BRIEF.md
# Serial Link Wake Signaling Controller

This block governs the low-power state of a codec's serial audio link and the way the codec tells the host that it wants to come back. Software writes a power-down request, and the link leaves its active state. While the link is down, an enabled wake event (for example a touch detection from a neighbouring block) is reported on one of two paths. The first path raises a dedicated interrupt output, which stays high until software clears it. The second path, chosen by a routing bit, forces the serial data-in line high.

On the data-in path the forced level is held until the block has seen the controller's frame sync go high and then low. The block then waits for a warm reset, which returns the link to its active state. A warm reset is a sync pulse held high for at least a configurable number of local clock cycles (1 µs by default) while no bit clock is running. The bit clock is stopped during power-down, so sync and bit clock are sampled with a free-running local clock through two-flop synchronisers.

Top module: `link_wake_ctrl`

## Requirements
- R1: After synchronous reset, `link_up` is 1, and `wake_irq` and `sdin_force` are 0.
- R2: A `pd_req` pulse while the link is active makes `link_up` 0 from the next clock edge.
- R3: While powered down with `wake_en`=1 and `route_sdin`=0, a `wake_evt` sets `wake_irq` to 1. It stays 1, even after the link returns, until an `irq_clr` pulse. When the set and the clear fall in the same cycle, the set wins.
- R4: While powered down with `wake_en`=1 and `route_sdin`=1, a `wake_evt` sets `sdin_force` to 1 and leaves `wake_irq` at 0.
- R5: `sdin_force` stays 1 until the synchronised sync has been seen high and then low. It falls on the third clock edge after `sync_in` is first sampled low.
- R6: A sync pulse whose synchronised high time reaches `WARM_CYC` cycles with the bit clock idle is a warm reset. When the pulse falls, the link becomes active. This also applies from plain power-down with no wake.
- R7: A sync pulse shorter than `WARM_CYC` releases `sdin_force` but leaves `link_up` at 0 until a later warm reset.
- R8: `wake_evt` has no effect while the link is active, and has no effect while powered down with `wake_en`=0.
- R9: The bit clock counts as idle only after `IDLE_CYC` cycles with no synchronised edge. Any edge restarts the warm-reset high-time count, so a sync pulse during bit-clock activity is not a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_req | input | 1 | Pulse: write 1 to the link power-down bit |
| wake_en | input | 1 | Wake events enabled |
| route_sdin | input | 1 | 1: signal wake on data-in; 0: on the interrupt pin |
| irq_clr | input | 1 | Pulse: write-1-to-clear of the interrupt status |
| wake_evt | input | 1 | Wake event, synchronous to clk |
| sync_in | input | 1 | Frame sync from the controller, asynchronous |
| bclk_in | input | 1 | Link bit clock, asynchronous, stopped when down |
| wake_irq | output | 1 | Wake interrupt, sticky |
| sdin_force | output | 1 | Forces the serial data-in line high |
| link_up | output | 1 | Link active |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a wake event that sets the interrupt and a software clear of that interrupt. The bench applies `irq_clr` in the very cycle of the accepted wake and expects the interrupt to stay set. The second pair is the end of the data-in handshake and the recognition of a warm reset, which both happen on the same falling sync. A long pulse must release the forced line and restore the link on the same edge, and a short pulse must release the line only. A behavioural model in the bench, fed by the same stimulus, predicts all three outputs on every clock, including the synchroniser delays.

// File: rtl/lwk_pkg.sv
// Shared types for the link wake controller.
package lwk_pkg;
    typedef enum logic [2:0] {
        ST_LINK_UP       = 3'd0,
        ST_POWER_DOWN    = 3'd1,
        ST_WAKE_SIGNAL   = 3'd2,
        ST_WAIT_SYNC_LOW = 3'd3,
        ST_WAIT_WARM_RST = 3'd4
    } lwk_state_e;
endpackage

// File: rtl/lwk_sync2.sv
// Two-flop synchroniser, W independent bits.
// Assumes: each bit is a level that may change at any time; no bus coherence is implied.
module lwk_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages per bit to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/lwk_warm_det.sv
// Warm-reset detector: reports a sync pulse that stayed high WARM_CYC cycles
// while the bit clock was idle. The report comes on the falling edge of the pulse.
// Assumes: inputs are already synchronised to clk.
module lwk_warm_det #(
    parameter int WARM_CYC = 100,
    parameter int IDLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_s,
    input  logic bclk_s,
    output logic warm
);
    localparam int HW = $clog2(WARM_CYC + 1);
    localparam int IW = $clog2(IDLE_CYC + 1);
    localparam logic [HW-1:0] HI_MAX   = HW'(WARM_CYC);
    localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYC);

    logic          bclk_d, sync_d;
    logic [IW-1:0] idle_cnt;
    logic [HW-1:0] hi_cnt;
    logic          bclk_idle;

    assign bclk_idle = (idle_cnt == IDLE_MAX);

    // Delayed copies for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_d <= 1'b0;
            sync_d <= 1'b0;
        end else begin
            bclk_d <= bclk_s;
            sync_d <= sync_s;
        end
    end

    // Cycles since the last bit-clock edge, saturating at IDLE_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                 idle_cnt <= '0;
        else if (bclk_s != bclk_d)  idle_cnt <= '0;
        else if (!bclk_idle)        idle_cnt <= idle_cnt + 1'b1;
    end

    // Sync high time with the bit clock idle, saturating at WARM_CYC.
    always_ff @(posedge clk) begin
        if (!rst_n)                   hi_cnt <= '0;
        else if (!sync_s || !bclk_idle) hi_cnt <= '0;
        else if (hi_cnt != HI_MAX)    hi_cnt <= hi_cnt + 1'b1;
    end

    assign warm = sync_d && !sync_s && (hi_cnt == HI_MAX);

    AST_WARM_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cnt != '0) |-> $past(bclk_idle)); // R9
    AST_WARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> $past(sync_s) && $past(hi_cnt != '0)); // R6
endmodule

// File: rtl/lwk_fsm.sv
// Link power state machine with the two wake-signalling paths.
// Assumes: sync_s is synchronised, warm is a single-cycle report, and
// wake_evt / control inputs are synchronous to clk.
module lwk_fsm
    import lwk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic wake_en,
    input  logic route_sdin,
    input  logic irq_clr,
    input  logic wake_evt,
    input  logic sync_s,
    input  logic warm,
    output logic wake_irq,
    output logic sdin_force,
    output logic link_up
);
    lwk_state_e state, state_nx;
    logic       wake_ok;
    logic       irq_set;

    assign wake_ok = (state == ST_POWER_DOWN) && wake_en && wake_evt && !warm;
    assign irq_set = wake_ok && !route_sdin;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LINK_UP:       if (pd_req) state_nx = ST_POWER_DOWN;
            ST_POWER_DOWN: begin
                if (warm)         state_nx = ST_LINK_UP;
                else if (wake_ok) state_nx = route_sdin ? ST_WAKE_SIGNAL : ST_WAIT_WARM_RST;
            end
            ST_WAKE_SIGNAL:   if (sync_s) state_nx = ST_WAIT_SYNC_LOW;
            ST_WAIT_SYNC_LOW: if (!sync_s) state_nx = warm ? ST_LINK_UP : ST_WAIT_WARM_RST;
            ST_WAIT_WARM_RST: if (warm) state_nx = ST_LINK_UP;
            default:          state_nx = ST_LINK_UP;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LINK_UP;
        else        state <= state_nx;
    end

    // Sticky interrupt; a set in the same cycle as a clear wins.
    always_ff @(posedge clk) begin
        if (!rst_n)       wake_irq <= 1'b0;
        else if (irq_set) wake_irq <= 1'b1;
        else if (irq_clr) wake_irq <= 1'b0;
    end

    assign sdin_force = (state == ST_WAKE_SIGNAL) || (state == ST_WAIT_SYNC_LOW);
    assign link_up    = (state == ST_LINK_UP);

    AST_PD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && pd_req) |=> !link_up); // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && !irq_clr) |=> wake_irq); // R3
    AST_FORCE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sdin_force) |-> $past(!sync_s) && !link_up || $past(warm)); // R5
    AST_UP_BY_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(warm)); // R6
    AST_NO_WAKE_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |=> !sdin_force && !$rose(wake_irq)); // R8
endmodule

// File: rtl/link_wake_ctrl.sv
// Top of the serial link wake controller: synchronises sync and bit clock,
// detects warm resets and runs the link power state machine.
// Assumes: clk is free-running and keeps running while the link is down.
module link_wake_ctrl #(
    parameter int WARM_CYC = 100,
    parameter int IDLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_req,
    input  logic wake_en,
    input  logic route_sdin,
    input  logic irq_clr,
    input  logic wake_evt,
    input  logic sync_in,
    input  logic bclk_in,
    output logic wake_irq,
    output logic sdin_force,
    output logic link_up
);
    logic sync_s, bclk_s, warm;

    lwk_sync2 #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sync_in, bclk_in}),
        .q     ({sync_s, bclk_s})
    );

    lwk_warm_det #(.WARM_CYC(WARM_CYC), .IDLE_CYC(IDLE_CYC)) u_warm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_s (sync_s),
        .bclk_s (bclk_s),
        .warm   (warm)
    );

    lwk_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pd_req     (pd_req),
        .wake_en    (wake_en),
        .route_sdin (route_sdin),
        .irq_clr    (irq_clr),
        .wake_evt   (wake_evt),
        .sync_s     (sync_s),
        .warm       (warm),
        .wake_irq   (wake_irq),
        .sdin_force (sdin_force),
        .link_up    (link_up)
    );
endmodule

// File: tb/link_wake_ctrl_tb.sv
module link_wake_ctrl_tb;
    localparam int WARM = 100;
    localparam int IDLE = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_req = 0, wake_en = 0, route_sdin = 0, irq_clr = 0, wake_evt = 0;
    logic sync_in = 0, bclk_in = 0, bclk_run = 0;
    logic wake_irq, sdin_force, link_up;
    int   n_chk = 0, n_fail = 0;

    link_wake_ctrl #(.WARM_CYC(WARM), .IDLE_CYC(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_en(wake_en),
        .route_sdin(route_sdin), .irq_clr(irq_clr), .wake_evt(wake_evt),
        .sync_in(sync_in), .bclk_in(bclk_in),
        .wake_irq(wake_irq), .sdin_force(sdin_force), .link_up(link_up)
    );

    always #5 clk = ~clk;

    // Bit clock stand-in, toggled away from the active edge.
    always @(negedge clk) if (bclk_run) bclk_in <= ~bclk_in;

    // ---- behavioural reference model ----
    // mode: 0 up, 1 down, 2 forcing (wait sync high), 3 forcing (wait sync low), 4 wait warm
    int   m_mode;
    logic m_irq;
    logic sq[$];          // sync sampling pipeline (oldest first)
    logic bq[$];
    logic m_sync_prev, m_bclk_prev;
    int   m_quiet, m_high;

    task automatic model_reset();
        m_mode = 0; m_irq = 0;
        sq = '{1'b0, 1'b0}; bq = '{1'b0, 1'b0};
        m_sync_prev = 0; m_bclk_prev = 0; m_quiet = 0; m_high = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            logic s, b, warm, accept;
            s = sq[0]; b = bq[0];
            warm = m_sync_prev && !s && (m_high >= WARM);
            accept = (m_mode == 1) && wake_en && wake_evt && !warm;
            if (accept && !route_sdin) m_irq = 1;
            else if (irq_clr) m_irq = 0;
            case (m_mode)
                0: if (pd_req) m_mode = 1;
                1: if (warm) m_mode = 0; else if (accept) m_mode = route_sdin ? 2 : 4;
                2: if (s) m_mode = 3;
                3: if (!s) m_mode = warm ? 0 : 4;
                4: if (warm) m_mode = 0;
                default: m_mode = 0;
            endcase
            m_high = (!s || m_quiet < IDLE) ? 0 : ((m_high < WARM) ? m_high + 1 : m_high);
            m_quiet = (b != m_bclk_prev) ? 0 : ((m_quiet < IDLE) ? m_quiet + 1 : m_quiet);
            m_sync_prev = s; m_bclk_prev = b;
            void'(sq.pop_front()); sq.push_back(sync_in);
            void'(bq.pop_front()); bq.push_back(bclk_in);
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) if (rst_n) begin
        check("R3 wake_irq",  wake_irq,   m_irq);
        check("R5 sdin_force", sdin_force, (m_mode == 2 || m_mode == 3));
        check("R6 link_up",   link_up,    (m_mode == 0));
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_pd();  pd_req = 1; cyc(1); pd_req = 0; endtask
    task automatic pulse_wake(); wake_evt = 1; cyc(1); wake_evt = 0; endtask
    task automatic sync_pulse(input int hi); sync_in = 1; cyc(hi); sync_in = 0; endtask

    initial begin
        fork
            begin : watchdog
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none

        cyc(4); rst_n = 1; cyc(1);
        check("R1 link_up after reset", link_up, 1'b1);
        check("R1 wake_irq after reset", wake_irq, 1'b0);
        check("R1 sdin_force after reset", sdin_force, 1'b0);

        // R8: wake while the link is up
        bclk_run = 1; wake_en = 1; cyc(5);
        pulse_wake(); cyc(3);
        check("R8 wake ignored while up (irq)", wake_irq, 1'b0);
        check("R8 wake ignored while up (link)", link_up, 1'b1);

        // R2: power down
        pulse_pd();
        check("R2 link down after pd_req", link_up, 1'b0);
        bclk_run = 0; cyc(20);

        // R8: wake with wake disabled
        wake_en = 0; pulse_wake(); cyc(3);
        check("R8 disabled wake (irq)", wake_irq, 1'b0);
        check("R8 disabled wake (force)", sdin_force, 1'b0);

        // R3: interrupt path, clear in the same cycle as the set
        wake_en = 1; route_sdin = 0;
        wake_evt = 1; irq_clr = 1; cyc(1); wake_evt = 0; irq_clr = 0;
        check("R3 set beats clear", wake_irq, 1'b1);
        check("R3 no data-in force on irq path", sdin_force, 1'b0);

        // R9: bit clock running during the sync pulse
        bclk_run = 1; sync_in = 1; cyc(120); bclk_run = 0; cyc(20); sync_in = 0; cyc(6);
        check("R9 active bit clock blocks warm reset", link_up, 1'b0);
        cyc(20);

        // R6: proper warm reset
        sync_pulse(130); cyc(6);
        check("R6 warm reset restores link", link_up, 1'b1);
        check("R3 irq stays after link returns", wake_irq, 1'b1);
        irq_clr = 1; cyc(1); irq_clr = 0;
        check("R3 irq cleared by write-1", wake_irq, 1'b0);

        // R4/R5/R7: data-in path with a short handshake pulse
        bclk_run = 1; cyc(5); pulse_pd(); bclk_run = 0; cyc(20);
        route_sdin = 1; pulse_wake();
        check("R4 data-in forced", sdin_force, 1'b1);
        check("R4 no irq on data-in path", wake_irq, 1'b0);
        sync_in = 1; cyc(5);
        check("R5 held while sync high", sdin_force, 1'b1);
        sync_in = 0; cyc(2);
        check("R5 held until low seen", sdin_force, 1'b1);
        cyc(1);
        check("R5 released after sync low", sdin_force, 1'b0);
        check("R7 short pulse leaves link down", link_up, 1'b0);
        cyc(20); sync_pulse(130); cyc(6);
        check("R7 later warm reset restores link", link_up, 1'b1);

        // R6: long pulse ends handshake and restores link together
        bclk_run = 1; cyc(5); pulse_pd(); bclk_run = 0; cyc(20);
        pulse_wake(); sync_pulse(130); cyc(6);
        check("R6 long pulse releases force", sdin_force, 1'b0);
        check("R6 long pulse restores link", link_up, 1'b1);

        // R6: host-initiated warm reset from plain power-down
        pulse_pd(); cyc(20); sync_pulse(130); cyc(6);
        check("R6 warm reset without wake", link_up, 1'b1);

        cyc(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule